// File: doc/BRIEF.md
# Key-Sequence Write Guard

This block keeps a group of protected configuration registers closed to writes until software writes two key bytes, in a fixed order, to one dedicated key address on a simple register bus. The bus has a write strobe, an address and an 8-bit data byte. The block watches that bus and produces a registered write-permit level. It also produces a gated write strobe, which the protected registers use as their write enable.

The lock state is held in flops that are cleared only by the power-on reset. The system reset clears the gated strobe pipeline but leaves the lock state alone. A protection that was opened therefore survives a system reset. Any wrong key byte written to the key address closes the block again at once.

Top module: `prot_key_guard`

## Requirements
- R1: While `por` is high and on the first cycle after it falls, `wr_permit_o`, `key_armed_o` and `prot_we_o` are all 0.
- R2: `sys_rst` leaves `wr_permit_o` and `key_armed_o` unchanged.
- R3: A key-address write of 0xCA followed by a key-address write of 0x53 sets `wr_permit_o` on the clock edge that samples the 0x53 write. After that edge `key_armed_o` is 0.
- R4: A key-address write of any value other than 0xCA, and other than an accepted 0x53, clears both `wr_permit_o` and `key_armed_o` on the edge that samples it.
- R5: A 0x53 written to the key address is accepted only when `key_armed_o` is 1. Otherwise it counts as a wrong key and the block stays locked.
- R6: While `wr_permit_o` is 0, `prot_we_o` stays 0 on the next cycle whatever is written.
- R7: While `wr_permit_o` is 1, a write to an address other than the key address raises `prot_we_o` for one cycle, on the edge that samples the write. A write to the key address never raises `prot_we_o`.
- R8: A 0xCA written to the key address in any state clears `wr_permit_o` and sets `key_armed_o`.
- R9: Writes to other addresses, and cycles with `wr_en` low, leave `wr_permit_o` and `key_armed_o` unchanged.
- R10: `sys_rst` high on an edge forces `prot_we_o` to 0 after that edge, even for a permitted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high; clears only the strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| wr_permit_o | output | 1 | Registered write-permit level |
| key_armed_o | output | 1 | First key seen, waiting for the second |
| prot_we_o | output | 1 | Gated write enable for the protected registers |

## Verification
The bench builds the block with its defaults: a 4-bit address and the key at address 0xF. That gives fifteen non-key addresses, so random traffic often lands between the two key bytes and exercises interrupted sequences. Random data is weighted toward 0xCA and 0x53, so that repeated first keys, stray second keys and relocks from the open state all occur many times. Directed cases cover power-on reset from the open state and a system reset during a permitted write.

// File: rtl/prot_key_pkg.sv
package prot_key_pkg;

    localparam int          KEY_W       = 8;
    localparam logic [7:0]  KEY_FIRST   = 8'hCA;
    localparam logic [7:0]  KEY_SECOND  = 8'h53;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic key_wr;     // write aimed at the key address
        logic is_first;   // data equals first key
        logic is_second;  // data equals second key
    } key_evt_t;

    // Next lock state for one bus cycle.
    function automatic lock_state_e lock_next(lock_state_e cur, key_evt_t ev);
        lock_state_e nxt;
        nxt = cur;
        if (ev.key_wr) begin
            if (ev.is_first)
                nxt = LK_ARMED;
            else if (ev.is_second && cur == LK_ARMED)
                nxt = LK_OPEN;
            else
                nxt = LK_CLOSED;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/prot_key_decode.sv
module prot_key_decode
    import prot_key_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output key_evt_t          evt,
    output logic              other_wr
);

    logic addr_hit;

    always_comb begin
        addr_hit      = (wr_addr == KEY_ADDR);
        evt.key_wr    = wr_en && addr_hit;
        evt.is_first  = (wr_data == KEY_FIRST);
        evt.is_second = (wr_data == KEY_SECOND);
        other_wr      = wr_en && !addr_hit;
    end

endmodule

// File: rtl/prot_key_fsm.sv
module prot_key_fsm
    import prot_key_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  key_evt_t evt,
    output logic     permit,
    output logic     armed
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = lock_next(state_q, evt);
    end

    // Only the power-on reset touches the lock state.
    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= LK_CLOSED;
            permit  <= 1'b0;
            armed   <= 1'b0;
        end else begin
            state_q <= state_d;
            permit  <= (state_d == LK_OPEN);
            armed   <= (state_d == LK_ARMED);
        end
    end

endmodule

// File: rtl/prot_key_gate.sv
module prot_key_gate (
    input  logic clk,
    input  logic por,
    input  logic sys_rst,
    input  logic other_wr,
    input  logic permit,
    output logic prot_we
);

    always_ff @(posedge clk) begin
        if (por || sys_rst)
            prot_we <= 1'b0;
        else
            prot_we <= other_wr && permit;
    end

endmodule

// File: rtl/prot_key_guard.sv
module prot_key_guard
    import prot_key_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_permit_o,
    output logic              key_armed_o,
    output logic              prot_we_o
);

    key_evt_t evt;
    logic     other_wr;
    logic     permit;
    logic     armed;

    prot_key_decode #(
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (KEY_ADDR)
    ) u_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt      (evt),
        .other_wr (other_wr)
    );

    prot_key_fsm u_fsm (
        .clk    (clk),
        .por    (por),
        .evt    (evt),
        .permit (permit),
        .armed  (armed)
    );

    prot_key_gate u_gate (
        .clk      (clk),
        .por      (por),
        .sys_rst  (sys_rst),
        .other_wr (other_wr),
        .permit   (permit),
        .prot_we  (prot_we_o)
    );

    assign wr_permit_o = permit;
    assign key_armed_o = armed;

endmodule

// File: rtl/prot_key_guard_chk.sv
module prot_key_guard_chk
    import prot_key_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '1
) (
    input logic              clk,
    input logic              por,
    input logic              sys_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              wr_permit_o,
    input logic              key_armed_o,
    input logic              prot_we_o
);

    logic key_w;
    logic oth_w;
    assign key_w = wr_en && (wr_addr == KEY_ADDR);
    assign oth_w = wr_en && (wr_addr != KEY_ADDR);

    AST_SECOND_OPENS: assert property (@(posedge clk) disable iff (por)
        key_w && wr_data == KEY_SECOND && key_armed_o |=> wr_permit_o && !key_armed_o); // R3

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (por)
        key_w && wr_data != KEY_FIRST && !(wr_data == KEY_SECOND && key_armed_o)
        |=> !wr_permit_o && !key_armed_o); // R4

    AST_STRAY_SECOND: assert property (@(posedge clk) disable iff (por)
        key_w && wr_data == KEY_SECOND && !key_armed_o |=> !wr_permit_o); // R5

    AST_LOCKED_NO_WE: assert property (@(posedge clk) disable iff (por)
        !wr_permit_o |=> !prot_we_o); // R6

    AST_KEY_ADDR_NO_WE: assert property (@(posedge clk) disable iff (por)
        key_w |=> !prot_we_o); // R7

    AST_FIRST_ARMS: assert property (@(posedge clk) disable iff (por)
        key_w && wr_data == KEY_FIRST |=> key_armed_o && !wr_permit_o); // R8

    AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (por)
        !key_w |=> $stable(wr_permit_o) && $stable(key_armed_o)); // R9

    AST_SYSRST_KEEPS: assert property (@(posedge clk) disable iff (por)
        sys_rst && !key_w |=> $stable(wr_permit_o) && $stable(key_armed_o)); // R2

    AST_SYSRST_DROPS_WE: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> !prot_we_o); // R10

    AST_OPEN_PASSES_WE: assert property (@(posedge clk) disable iff (por)
        oth_w && wr_permit_o && !sys_rst |=> prot_we_o); // R7

    AST_POR_CLEARS: assert property (@(posedge clk)
        por |=> !wr_permit_o && !key_armed_o && !prot_we_o); // R1

endmodule

bind prot_key_guard prot_key_guard_chk #(
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR)
) u_chk (
    .clk         (clk),
    .por         (por),
    .sys_rst     (sys_rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_permit_o (wr_permit_o),
    .key_armed_o (key_armed_o),
    .prot_we_o   (prot_we_o)
);

// File: tb/prot_key_guard_test.sv
module prot_key_guard_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 4;
    localparam logic [3:0]  KADDR      = 4'hF;
    localparam logic [7:0]  K1         = 8'hCA;
    localparam logic [7:0]  K2         = 8'h53;

    logic              clk = 1'b0;
    logic              por = 1'b1;
    logic              sys_rst = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              wr_permit_o;
    logic              key_armed_o;
    logic              prot_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model: 0 closed, 1 armed, 2 open
    int  m_state = 0;
    bit  m_we    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_key_guard #(.ADDR_W(ADDR_W), .KEY_ADDR(KADDR)) uut (
        .clk(clk), .por(por), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit_o(wr_permit_o),
        .key_armed_o(key_armed_o), .prot_we_o(prot_we_o)
    );

    function automatic int model_next(int s, bit en, logic [3:0] a, logic [7:0] d);
        if (!(en && a == KADDR)) return s;          // R9
        if (d == K1) return 1;                      // R8
        if (d == K2 && s == 1) return 2;            // R3
        return 0;                                   // R4, R5
    endfunction

    task automatic check(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(wr_permit_o, m_state == 2, {req, " permit"});
        check(key_armed_o, m_state == 1, {req, " armed"});
        check(prot_we_o,   m_we,         {req, " prot_we"});
    endtask

    // Called at a falling edge: drive, clock, update model, sample.
    task automatic step(input bit en, input logic [3:0] a, input logic [7:0] d,
                        input bit srst, input string req);
        wr_en = en; wr_addr = a; wr_data = d; sys_rst = srst;
        @(posedge clk);
        m_we    = en && (a != KADDR) && (m_state == 2) && !srst;
        m_state = model_next(m_state, en, a, d);
        @(negedge clk);
        wr_en = 1'b0; sys_rst = 1'b0;
        check_all(req);
    endtask

    task automatic do_por();
        por = 1'b1;
        @(posedge clk); @(negedge clk);
        m_state = 0; m_we = 1'b0;
        check_all("R1 during por");
        por = 1'b0;
        @(posedge clk); @(negedge clk);
        check_all("R1 after por");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_por();

        // R6: locked, protected write blocked
        step(1, 4'h2, 8'h11, 0, "R6");
        step(0, 4'h0, 8'h00, 0, "R6");
        // R5: stray second key
        step(1, KADDR, K2, 0, "R5");
        // R3: good sequence
        step(1, KADDR, K1, 0, "R3 first");
        step(1, KADDR, K2, 0, "R3 second");
        // R7: permitted write, key-address write gives no strobe
        step(1, 4'h3, 8'h77, 0, "R7");
        step(1, KADDR, K1, 0, "R7 key addr");   // also R8 relock
        step(1, KADDR, K2, 0, "R8 reopen");
        // R2 / R10: system reset during permitted write
        step(1, 4'h4, 8'h01, 1, "R10");
        step(0, 4'h0, 8'h00, 1, "R2");
        step(1, 4'h4, 8'h02, 0, "R2 still open");
        // R4: wrong key relocks
        step(1, KADDR, 8'h00, 0, "R4");
        step(1, 4'h4, 8'h03, 0, "R6 after relock");
        // R9: interleaved other write does not break sequence
        step(1, KADDR, K1, 0, "R9 first");
        step(1, 4'h5, K2, 0, "R9 other addr");
        step(0, KADDR, 8'h00, 0, "R9 idle");
        step(1, KADDR, K2, 0, "R9 second");
        // R4: wrong key while armed
        step(1, KADDR, K1, 0, "R4 arm");
        step(1, KADDR, 8'h54, 0, "R4 armed wrong");
        // R1: power-on reset from open
        step(1, KADDR, K1, 0, "R1 arm");
        step(1, KADDR, K2, 0, "R1 open");
        do_por();

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit         en;
            logic [3:0] a;
            logic [7:0] d;
            bit         sr;
            int         r;
            en = ($urandom % 10) < 8;
            a  = ($urandom % 2) ? KADDR : 4'($urandom % 15);
            r  = $urandom % 10;
            d  = (r < 3) ? K1 : (r < 6) ? K2 : 8'($urandom);
            sr = ($urandom % 20) == 0;
            step(en, a, d, sr, "R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule